// File: doc/BRIEF.md
# Infrared Remote Frame Decoder (Manchester, 14-bit)

This block turns the demodulated output of an infrared receiver into decoded remote-control frames. The receiver line is active low: it idles high, and it goes low while carrier is present. A frame has fourteen Manchester-coded bit cells. The first two cells are start bits, both carrying a 1. They are followed by a toggle bit, a 5-bit system address and a 6-bit command, each sent most significant bit first. A logic 1 is sent as a high half-cell followed by a low half-cell, and a logic 0 as the reverse.

Timing comes from a coarse tick made by dividing the clock. A tick counter restarts on every mid-cell transition, so the decoder follows a transmitter whose bit rate is a little off nominal. Each data cell is sampled a quarter of a cell into the cell, and its mid-cell transition must arrive within three quarters of a cell. Otherwise the frame is abandoned and an all-ones fault code is reported. A decoded frame is reported once on a one-cycle pulse, and the fields stay on the outputs until the next result.

Top module: `ir_frame_decoder`

## Requirements
- R1: After reset, `sys_o` and `cmd_o` read 0, and `valid_o` and `fault_o` stay low until a frame ends.
- R2: A frame starts only with a falling edge seen while the decoder is armed. The decoder becomes armed once the line has been seen high. Two start cells, each a 1, must be followed by exactly 12 data cells.
- R3: Data cells arrive most significant bit first, in this order: toggle, 5 system bits, 6 command bits. `sys_o[4:0]` holds the 5 system bits.
- R4: On a good frame, `cmd_o[5:0]` holds the command, `cmd_o[6]` holds the toggle bit and `cmd_o[7]` is 0.
- R5: Each data cell is sampled SAMPLE_T ticks after the previous mid-cell edge, which is a quarter cell into the cell. A high level gives 1 and a low level gives 0. Frames whose bit time is off nominal by up to 7% still decode.
- R6: The decoder waits for a falling edge after a sampled 1 and for a rising edge after a sampled 0. If that mid-cell edge has not come LIMIT_T ticks after the previous one, the frame aborts: `fault_o` pulses, and `sys_o` and `cmd_o` become all ones.
- R7: A missing start transition also aborts the frame with the same fault code. This covers the rising edge at the second start cell's boundary and the falling edge at its middle.
- R8: `valid_o` and `fault_o` are single-cycle pulses that are never high together. `sys_o` and `cmd_o` change only in a cycle that has one of these pulses.
- R9: After any result, a new frame is decoded only after the line has been high. A line held low after a fault does not start a frame.
- R10: While `en_i` is low, a frame in progress is dropped without any pulse, and the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Decoder enable |
| ir_ni | input | 1 | Demodulated infrared line, active low, asynchronous |
| sys_o | output | SYS_W | System address of the last frame, or all ones after a fault |
| cmd_o | output | CMD_W+2 | {0, toggle, command} of the last frame, or all ones after a fault |
| valid_o | output | 1 | One-cycle pulse when a frame decoded correctly |
| fault_o | output | 1 | One-cycle pulse when a frame aborted |

## Verification
The assertions assume reset is applied at the start, and that `en_i` changes only between clock edges. They do not depend on any property of the line, since any waveform on `ir_ni` must still give exclusive single-cycle pulses and stable outputs between them. The stimulus changes the line only on falling clock edges. It spaces frames far enough apart that each result comes out before the next frame starts. It keeps skewed bit times within the sample and timeout windows, so every frame has exactly one expected outcome.

// File: rtl/irdec_pkg.sv
package irdec_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,    // wait for the line to be high
      ST_ARMED,   // wait for the first falling edge
      ST_START1,  // wait for the rising edge at the second start cell
      ST_START2,  // wait for the falling edge in the middle of the second start cell
      ST_SAMPLE,  // wait for the sample point of a data cell
      ST_EDGE     // wait for the mid-cell transition
   } irdec_state_e;
endpackage

// File: rtl/irdec_sync.sv
module irdec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_ni,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[g] <= 1'b1;
            else         chain[g] <= line_ni;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[g] <= 1'b1;
            else         chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev <= 1'b1;
      else         prev <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/irdec_tick.sv
module irdec_tick #(
   parameter int DIV     = 256,
   parameter int TMR_W   = 6,
   parameter int TMR_MAX = 35
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   output logic [TMR_W-1:0] ticks_o
);
   logic tick;

   if (DIV == 1) begin : g_nodiv
      assign tick = ~restart_i;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                 pre <= '0;
         else if (restart_i)          pre <= '0;
         else if (pre == PW'(DIV-1))  pre <= '0;
         else                         pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(DIV-1)) & ~restart_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ticks_o <= '0;
      else if (restart_i)                             ticks_o <= '0;
      else if (tick && ticks_o != TMR_W'(TMR_MAX))    ticks_o <= ticks_o + 1'b1;
   end
endmodule

// File: rtl/irdec_fsm.sv
module irdec_fsm
   import irdec_pkg::*;
#(
   parameter int SYS_W    = 5,
   parameter int CMD_W    = 6,
   parameter int TMR_W    = 6,
   parameter int SAMPLE_T = 21,
   parameter int LIMIT_T  = 35
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               level_i,
   input  logic               rise_i,
   input  logic               fall_i,
   input  logic [TMR_W-1:0]   ticks_i,
   output logic               restart_o,
   output logic [SYS_W-1:0]   sys_o,
   output logic [CMD_W+1:0]   cmd_o,
   output logic               valid_o,
   output logic               fault_o
);
   localparam int NBITS = 1 + SYS_W + CMD_W;
   localparam int CNT_W = $clog2(NBITS + 1);

   irdec_state_e       state;
   logic [CNT_W-1:0]   bitcnt;
   logic [NBITS-1:0]   shreg;
   logic               want_fall;
   logic               edge_ok, at_sample, at_limit, abort_now, done_now;

   assign edge_ok   = want_fall ? fall_i : rise_i;
   assign at_sample = ticks_i >= TMR_W'(SAMPLE_T);
   assign at_limit  = ticks_i >= TMR_W'(LIMIT_T);

   always_comb begin
      restart_o = 1'b0;
      abort_now = 1'b0;
      done_now  = 1'b0;
      if (en_i) begin
         case (state)
            ST_ARMED:  restart_o = fall_i;
            ST_START1: abort_now = ~rise_i & at_sample;
            ST_START2: begin
               restart_o = fall_i;
               abort_now = ~fall_i & at_limit;
            end
            ST_EDGE: begin
               restart_o = edge_ok;
               abort_now = ~edge_ok & at_limit;
               done_now  = edge_ok & (bitcnt == CNT_W'(1));
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         want_fall <= 1'b0;
         sys_o     <= '0;
         cmd_o     <= '0;
         valid_o   <= 1'b0;
         fault_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         fault_o <= 1'b0;
         if (!en_i) begin
            state <= ST_IDLE;
         end else if (abort_now) begin
            sys_o   <= '1;
            cmd_o   <= '1;
            fault_o <= 1'b1;
            state   <= ST_IDLE;
         end else if (done_now) begin
            sys_o   <= shreg[CMD_W +: SYS_W];
            cmd_o   <= {1'b0, shreg[NBITS-1], shreg[CMD_W-1:0]};
            valid_o <= 1'b1;
            state   <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE:   if (level_i) state <= ST_ARMED;
               ST_ARMED:  if (fall_i)  state <= ST_START1;
               ST_START1: if (rise_i)  state <= ST_START2;
               ST_START2: if (fall_i) begin
                  bitcnt <= CNT_W'(NBITS);
                  state  <= ST_SAMPLE;
               end
               ST_SAMPLE: if (at_sample) begin
                  shreg     <= {shreg[NBITS-2:0], level_i};
                  want_fall <= level_i;
                  state     <= ST_EDGE;
               end
               ST_EDGE: if (edge_ok) begin
                  bitcnt <= bitcnt - 1'b1;
                  state  <= ST_SAMPLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder #(
   parameter int TICK_DIV    = 256,
   parameter int BIT_TICKS   = 28,
   parameter int SYS_W       = 5,
   parameter int CMD_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               ir_ni,
   output logic [SYS_W-1:0]   sys_o,
   output logic [CMD_W+1:0]   cmd_o,
   output logic               valid_o,
   output logic               fault_o
);
   localparam int HALF_T   = BIT_TICKS / 2;
   localparam int SAMPLE_T = HALF_T + BIT_TICKS / 4;
   localparam int LIMIT_T  = HALF_T + (3 * BIT_TICKS) / 4;
   localparam int TMR_W    = $clog2(LIMIT_T + 1);
   localparam int OCMD_W   = CMD_W + 2;

   initial begin
      assert (BIT_TICKS >= 8 && BIT_TICKS % 4 == 0)
         else $error("BIT_TICKS must be a multiple of 4, at least 8");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (TICK_DIV >= 1 && SYS_W >= 1 && CMD_W >= 1)
         else $error("TICK_DIV, SYS_W and CMD_W must be positive");
   end

   logic             level, rise, fall, restart;
   logic [TMR_W-1:0] ticks;

   irdec_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_ni(ir_ni),
      .level_o(level), .rise_o(rise), .fall_o(fall)
   );

   irdec_tick #(.DIV(TICK_DIV), .TMR_W(TMR_W), .TMR_MAX(LIMIT_T)) tick_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .ticks_o(ticks)
   );

   irdec_fsm #(
      .SYS_W(SYS_W), .CMD_W(CMD_W), .TMR_W(TMR_W),
      .SAMPLE_T(SAMPLE_T), .LIMIT_T(LIMIT_T)
   ) fsm_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
      .level_i(level), .rise_i(rise), .fall_i(fall), .ticks_i(ticks),
      .restart_o(restart), .sys_o(sys_o), .cmd_o(cmd_o),
      .valid_o(valid_o), .fault_o(fault_o)
   );
endmodule

// File: rtl/irdec_chk.sv
module irdec_chk #(
   parameter int SYS_W  = 5,
   parameter int OCMD_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              en_i,
   input logic [SYS_W-1:0]  sys_o,
   input logic [OCMD_W-1:0] cmd_o,
   input logic              valid_o,
   input logic              fault_o
);
   a_r8_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(valid_o && fault_o));

   a_r8_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   a_r8_fault_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |=> !fault_o);

   a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_o && !fault_o) |-> ($stable(sys_o) && $stable(cmd_o)));

   a_r6_fault_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (&sys_o && &cmd_o));

   a_r4_top_bit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> !cmd_o[OCMD_W-1]);

   a_r10_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!valid_o && !fault_o));
endmodule

bind ir_frame_decoder irdec_chk #(.SYS_W(SYS_W), .OCMD_W(OCMD_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sys_o(sys_o),
   .cmd_o(cmd_o), .valid_o(valid_o), .fault_o(fault_o)
);

// File: tb/ir_frame_decoder_tb_top.sv
module ir_frame_decoder_tb_top;
   localparam int TDIV = 4;
   localparam int BT   = 28;
   localparam int HALF = TDIV * BT / 2;   // clocks per half cell

   typedef struct packed {
      logic       flt;
      logic [4:0] sys;
      logic [7:0] cmd;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b1;
   logic       ir_n = 1'b1;
   logic [4:0] sys_o;
   logic [7:0] cmd_o;
   logic       valid_o, fault_o;

   int    checks = 0;
   int    fails  = 0;
   exp_t  q[$];
   string tagq[$];
   bit    prev_pulse = 1'b0;
   bit    done = 1'b0;

   always #5 clk = ~clk;

   ir_frame_decoder #(.TICK_DIV(TDIV), .BIT_TICKS(BT)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ir_ni(ir_n),
      .sys_o(sys_o), .cmd_o(cmd_o), .valid_o(valid_o), .fault_o(fault_o)
   );

   task automatic check(input bit ok, input string tag, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   // monitor: pops expected results as pulses appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prev_pulse)
            check(!valid_o && !fault_o, "R8",
                  $sformatf("pulse lasted two cycles: actual v=%0b f=%0b expected 0 0",
                            valid_o, fault_o));
         if (valid_o || fault_o) begin
            if (q.size() == 0) begin
               check(1'b0, "R10", $sformatf("unexpected pulse actual v=%0b f=%0b expected none",
                                            valid_o, fault_o));
            end else begin
               exp_t  e;
               exp_t  a;
               string t;
               e = q.pop_front();
               t = tagq.pop_front();
               a = '{flt: fault_o, sys: sys_o, cmd: cmd_o};
               check(a == e && (valid_o != fault_o), t,
                     $sformatf("actual flt=%0b sys=%h cmd=%h v=%0b expected flt=%0b sys=%h cmd=%h",
                               a.flt, a.sys, a.cmd, valid_o, e.flt, e.sys, e.cmd));
            end
         end
         prev_pulse = valid_o || fault_o;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: one frame; cut>0 omits the mid transition of cell 'cut'; en_off>0 drops en at that cell
   task automatic send_frame(input logic tog, input logic [4:0] s, input logic [5:0] c,
                             input int half, input int cut, input int en_off, input string tag);
      logic [13:0] cells;
      cells = {2'b11, tog, s, c};
      if (en_off == 0) begin
         if (cut > 0) q.push_back('{flt: 1'b1, sys: 5'h1f, cmd: 8'hff});
         else         q.push_back('{flt: 1'b0, sys: s, cmd: {1'b0, tog, c}});
         tagq.push_back(tag);
      end
      for (int i = 0; i < 14; i++) begin
         if (en_off > 0 && i == en_off) en = 1'b0;
         ir_n = cells[13-i];
         wait_clk(half);
         if (i == cut) begin
            wait_clk(6 * half);
            break;
         end
         ir_n = ~cells[13-i];
         wait_clk(half);
      end
      ir_n = 1'b1;
      wait_clk(4 * half);
      en = 1'b1;
   endtask

   initial begin
      logic [4:0] last_s;
      logic [7:0] last_c;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(1);
      // R1: reset state
      check(sys_o == 5'h00, "R1", $sformatf("sys_o actual %h expected 00", sys_o));
      check(cmd_o == 8'h00, "R1", $sformatf("cmd_o actual %h expected 00", cmd_o));
      check(!valid_o && !fault_o, "R1",
            $sformatf("pulses actual %0b%0b expected 00", valid_o, fault_o));
      wait_clk(200);

      // R2/R3/R4: fixed patterns
      send_frame(1'b0, 5'h00, 6'h00, HALF, -1, 0, "R2");
      send_frame(1'b1, 5'h1f, 6'h3f, HALF, -1, 0, "R4");
      send_frame(1'b0, 5'h15, 6'h2a, HALF, -1, 0, "R3");
      send_frame(1'b1, 5'h0a, 6'h15, HALF, -1, 0, "R4");
      for (int k = 0; k < 8; k++)
         send_frame(1'($urandom), 5'($urandom), 6'($urandom), HALF, -1, 0, "R3");

      // R5: bit-time skew
      send_frame(1'b1, 5'h13, 6'h0d, HALF - 4, -1, 0, "R5");
      send_frame(1'b0, 5'h0c, 6'h32, HALF + 4, -1, 0, "R5");

      // R6: missing mid-cell edge in a data cell and in the last cell
      send_frame(1'b0, 5'h05, 6'h11, HALF, 7, 0, "R6");
      send_frame(1'b1, 5'h1a, 6'h2e, HALF, 13, 0, "R6");
      // R7: missing falling edge of the second start cell
      send_frame(1'b1, 5'h01, 6'h01, HALF, 1, 0, "R7");
      // R7: missing rising edge at the second start cell (line stays low)
      q.push_back('{flt: 1'b1, sys: 5'h1f, cmd: 8'hff});
      tagq.push_back("R7");
      ir_n = 1'b0;
      wait_clk(8 * HALF);
      // R9: still low after the fault, then a clean frame
      check(q.size() == 0, "R9", $sformatf("pending results actual %0d expected 0", q.size()));
      ir_n = 1'b1;
      wait_clk(2 * HALF);
      send_frame(1'b0, 5'h07, 6'h24, HALF, -1, 0, "R9");

      // R10: enable dropped mid-frame
      last_s = sys_o;
      last_c = cmd_o;
      send_frame(1'b1, 5'h1e, 6'h03, HALF, -1, 6, "R10");
      check(sys_o == last_s && cmd_o == last_c, "R10",
            $sformatf("outputs actual %h/%h expected %h/%h", sys_o, cmd_o, last_s, last_c));
      send_frame(1'b1, 5'h11, 6'h1b, HALF, -1, 0, "R10");

      check(q.size() == 0, "R2", $sformatf("missing results actual %0d expected 0", q.size()));
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule